// File: doc/BRIEF.md
# Rename History Buffer with Rollback

This block keeps an ordered record of every destination-register rename made by one thread of an out-of-order core. Each record carries the instruction's sequence number, the architectural register written, the physical register just allocated, and the physical register that held the mapping before. Each renamed destination operand adds one record at the newest end. An instruction with two destinations adds two records with the same sequence number.

A squash with sequence number S walks back from the newest record and undoes every rename younger than S, one record per cycle. For each record it writes the old physical register back into the external rename table and hands the speculatively allocated register back to the external free list. A commit with sequence number C walks forward from the oldest record and retires every record at or below C, one per cycle. For each record it returns the *previous* physical register to the free list. It does not return the new one. A commit that finds nothing to retire is dropped, so a late or stale commit number does no harm. While either walk runs, `busy` is high and the rename stage must hold new renames. Two running counts of retired and undone records are exposed for verification.

Top module: `rename_history_buffer`

## Requirements
- R1: After reset the buffer is empty, `busy` is low, `restore_valid` and `free_valid` are low, and both counters read zero.
- R2: A push is recorded at the newest end and `count` rises by one the cycle after, when `push_valid` is high, `busy` is low, `squash_valid` is low and the buffer is not full. `count` never exceeds DEPTH.
- R3: A push is ignored, leaving `count` and the contents unchanged, when the buffer is full, when `busy` is high, or when `squash_valid` is high in the same cycle.
- R4: In the cycles after a squash with number S, while the newest record's number is greater than S (unsigned compare), one record per cycle is popped from the newest end. In that cycle `restore_valid` and `free_valid` are both high, `restore_arch`/`restore_phys` carry its architectural and previous physical register, and `free_phys` carries its new physical register.
- R5: In the cycles after an accepted commit with number C, while the oldest record's number is at most C, one record per cycle is popped from the oldest end. In that cycle `free_valid` is high, `restore_valid` is low, and `free_phys` carries the record's previous physical register.
- R6: A commit is ignored, with no walk and `busy` staying low, when the buffer is empty or the oldest record's number is greater than C.
- R7: A commit is ignored when `squash_valid` is high in the same cycle or when `busy` is high.
- R8: A squash always raises `busy` in the following cycle. On an empty buffer, or with no younger record, this lasts one cycle with no output.
- R9: `busy` stays high from the cycle after a walk starts through the first cycle in which the walk finds no matching record. In that cycle no output is valid. `free_valid` is never high while `busy` is low.
- R10: A squash arriving during a commit walk takes over at once: the commit walk stops and the rollback proceeds with the new number.
- R11: `commit_cnt` increments once for each record popped by a commit walk. `undo_cnt` increments once for each record popped by a rollback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Record a new rename |
| push_seq | input | SEQ_W | Sequence number of the renaming instruction |
| push_arch | input | ARCH_W | Architectural destination register |
| push_new | input | PHYS_W | Newly allocated physical register |
| push_prev | input | PHYS_W | Physical register previously mapped |
| squash_valid | input | 1 | Start a rollback |
| squash_seq | input | SEQ_W | Youngest surviving sequence number |
| commit_valid | input | 1 | Request retirement |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| busy | output | 1 | A walk is in progress; hold renames |
| full | output | 1 | Buffer holds DEPTH records |
| count | output | CW | Records held |
| restore_valid | output | 1 | Write the rename table |
| restore_arch | output | ARCH_W | Architectural register to restore |
| restore_phys | output | PHYS_W | Physical register to write back |
| free_valid | output | 1 | Return a register to the free list |
| free_phys | output | PHYS_W | Register returned |
| commit_cnt | output | CNT_W | Records retired by commit |
| undo_cnt | output | CNT_W | Records undone by rollback |

## Verification
A wrong ring pointer or a missed pop shows at the ports within one cycle of the next walk step. The record on `restore_*` or `free_phys` would name the wrong register, and `count` would drift from the number of pushes minus pops. A wrong walk state or a wrong latched limit appears as a pop that happens one cycle too many or too few, which makes `busy` fall on the wrong cycle and puts the counters out of step. The bench replays every push, squash and commit on a queue model. It compares all outputs every cycle, so any such divergence is reported in the cycle it first appears.

// File: rtl/hb_pkg.sv
`timescale 1ns/1ps
package hb_pkg;
  typedef enum logic [1:0] {
    WALK_IDLE   = 2'd0,
    WALK_UNDO   = 2'd1,
    WALK_RETIRE = 2'd2
  } walk_e;
endpackage

// File: rtl/hb_ring.sv
`timescale 1ns/1ps
module hb_ring #(
  parameter int DEPTH = 16,
  parameter int W     = 32,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_en,
  input  logic [W-1:0]  push_data,
  input  logic          pop_newest,
  input  logic          pop_oldest,
  output logic [W-1:0]  newest_data,
  output logic [W-1:0]  oldest_data,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] head;
  logic [PW-1:0] tail_idx;
  logic [PW-1:0] newest_idx;
  logic [CW-1:0] count_nxt;

  // Ring index advance by k places, modulo DEPTH.
  function automatic logic [PW-1:0] step(input logic [PW-1:0] p, input int unsigned k);
    int unsigned s;
    s = (32'(p) + k) % DEPTH;
    return PW'(s);
  endfunction

  assign tail_idx    = step(head, 32'(count));
  assign newest_idx  = step(head, 32'(count) + DEPTH - 1);
  assign newest_data = mem[newest_idx];
  assign oldest_data = mem[head];
  assign empty       = (count == '0);
  assign full        = (count == CW'(DEPTH));

  always_comb begin
    count_nxt = count;
    if (push_en) count_nxt = count_nxt + CW'(1);
    if (pop_newest || pop_oldest) count_nxt = count_nxt - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (push_en) mem[tail_idx] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      count <= '0;
    end else begin
      if (pop_oldest) head <= step(head, 1);
      count <= count_nxt;
    end
  end
endmodule

// File: rtl/hb_walk.sv
`timescale 1ns/1ps
module hb_walk #(
  parameter int SEQ_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             squash_req,
  input  logic [SEQ_W-1:0] squash_seq,
  input  logic             commit_req,
  input  logic [SEQ_W-1:0] commit_seq,
  input  logic             empty,
  input  logic [SEQ_W-1:0] newest_seq,
  input  logic [SEQ_W-1:0] oldest_seq,
  output logic             undo_act,
  output logic             retire_act,
  output logic             busy
);
  import hb_pkg::*;

  walk_e            state;
  logic [SEQ_W-1:0] limit;
  logic             commit_take;

  // True when sequence number a belongs to a younger instruction than b.
  function automatic logic younger(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
    return a > b;
  endfunction

  assign undo_act    = (state == WALK_UNDO)   && !empty && younger(newest_seq, limit);
  assign retire_act  = (state == WALK_RETIRE) && !empty && !younger(oldest_seq, limit);
  assign commit_take = (state == WALK_IDLE) && commit_req && !squash_req && !empty
                       && !younger(oldest_seq, commit_seq);
  assign busy        = (state != WALK_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= WALK_IDLE;
      limit <= '0;
    end else if (squash_req) begin
      state <= WALK_UNDO;
      limit <= squash_seq;
    end else if (commit_take) begin
      state <= WALK_RETIRE;
      limit <= commit_seq;
    end else if ((state == WALK_UNDO && !undo_act) || (state == WALK_RETIRE && !retire_act)) begin
      state <= WALK_IDLE;
    end
  end
endmodule

// File: rtl/rename_history_buffer.sv
`timescale 1ns/1ps
module rename_history_buffer #(
  parameter int DEPTH  = 16,
  parameter int SEQ_W  = 16,
  parameter int ARCH_W = 5,
  parameter int PHYS_W = 7,
  parameter int CNT_W  = 16,
  parameter int CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  input  logic [SEQ_W-1:0]  push_seq,
  input  logic [ARCH_W-1:0] push_arch,
  input  logic [PHYS_W-1:0] push_new,
  input  logic [PHYS_W-1:0] push_prev,
  input  logic              squash_valid,
  input  logic [SEQ_W-1:0]  squash_seq,
  input  logic              commit_valid,
  input  logic [SEQ_W-1:0]  commit_seq,
  output logic              busy,
  output logic              full,
  output logic [CW-1:0]     count,
  output logic              restore_valid,
  output logic [ARCH_W-1:0] restore_arch,
  output logic [PHYS_W-1:0] restore_phys,
  output logic              free_valid,
  output logic [PHYS_W-1:0] free_phys,
  output logic [CNT_W-1:0]  commit_cnt,
  output logic [CNT_W-1:0]  undo_cnt
);
  typedef struct packed {
    logic [SEQ_W-1:0]  seq;
    logic [ARCH_W-1:0] arch;
    logic [PHYS_W-1:0] pnew;
    logic [PHYS_W-1:0] pprev;
  } rec_t;
  localparam int RW = $bits(rec_t);

  rec_t newest, oldest, incoming;
  logic empty;
  logic push_accept;
  logic undo_act, retire_act;

  assign incoming    = '{seq: push_seq, arch: push_arch, pnew: push_new, pprev: push_prev};
  assign push_accept = push_valid && !busy && !squash_valid && !full;

  hb_ring #(.DEPTH(DEPTH), .W(RW), .CW(CW)) u_ring (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_en    (push_accept),
    .push_data  (incoming),
    .pop_newest (undo_act),
    .pop_oldest (retire_act),
    .newest_data(newest),
    .oldest_data(oldest),
    .count      (count),
    .empty      (empty),
    .full       (full)
  );

  hb_walk #(.SEQ_W(SEQ_W)) u_walk (
    .clk        (clk),
    .rst_n      (rst_n),
    .squash_req (squash_valid),
    .squash_seq (squash_seq),
    .commit_req (commit_valid),
    .commit_seq (commit_seq),
    .empty      (empty),
    .newest_seq (newest.seq),
    .oldest_seq (oldest.seq),
    .undo_act   (undo_act),
    .retire_act (retire_act),
    .busy       (busy)
  );

  assign restore_valid = undo_act;
  assign restore_arch  = undo_act ? newest.arch  : '0;
  assign restore_phys  = undo_act ? newest.pprev : '0;
  assign free_valid    = undo_act || retire_act;
  assign free_phys     = undo_act ? newest.pnew : (retire_act ? oldest.pprev : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      commit_cnt <= '0;
      undo_cnt   <= '0;
    end else begin
      if (retire_act) commit_cnt <= commit_cnt + CNT_W'(1);
      if (undo_act)   undo_cnt   <= undo_cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/hb_history_chk.sv
`timescale 1ns/1ps
module hb_history_chk #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push_valid,
  input logic             squash_valid,
  input logic             busy,
  input logic             full,
  input logic [CW-1:0]    count,
  input logic             restore_valid,
  input logic             free_valid,
  input logic [CNT_W-1:0] commit_cnt,
  input logic [CNT_W-1:0] undo_cnt
);
  assert_depth_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  assert_push_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !busy && !squash_valid && !full) |=> count == $past(count) + CW'(1));
  assert_full_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !busy) |=> count == $past(count));
  assert_restore_frees_R4: assert property (@(posedge clk) disable iff (!rst_n)
    restore_valid |-> free_valid);
  assert_undo_pops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    restore_valid |=> count == $past(count) - CW'(1));
  assert_squash_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    squash_valid |=> busy);
  assert_free_needs_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    free_valid |-> busy);
  assert_commit_cnt_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (free_valid && !restore_valid) |=> commit_cnt == $past(commit_cnt) + CNT_W'(1));
  assert_undo_cnt_R11: assert property (@(posedge clk) disable iff (!rst_n)
    restore_valid |=> undo_cnt == $past(undo_cnt) + CNT_W'(1));
endmodule

bind rename_history_buffer hb_history_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W), .CW(CW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .push_valid   (push_valid),
  .squash_valid (squash_valid),
  .busy         (busy),
  .full         (full),
  .count        (count),
  .restore_valid(restore_valid),
  .free_valid   (free_valid),
  .commit_cnt   (commit_cnt),
  .undo_cnt     (undo_cnt)
);

// File: tb/rename_history_buffer_tb.sv
`timescale 1ns/1ps
module rename_history_buffer_tb;
  localparam int DEPTH = 16, SEQ_W = 16, ARCH_W = 5, PHYS_W = 7, CNT_W = 16;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push_valid = 1'b0, squash_valid = 1'b0, commit_valid = 1'b0;
  logic [SEQ_W-1:0] push_seq = '0, squash_seq = '0, commit_seq = '0;
  logic [ARCH_W-1:0] push_arch = '0;
  logic [PHYS_W-1:0] push_new = '0, push_prev = '0;
  logic busy, full, restore_valid, free_valid;
  logic [CW-1:0] count;
  logic [ARCH_W-1:0] restore_arch;
  logic [PHYS_W-1:0] restore_phys, free_phys;
  logic [CNT_W-1:0] commit_cnt, undo_cnt;

  always #2.5 clk = ~clk;

  rename_history_buffer #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .ARCH_W(ARCH_W),
                          .PHYS_W(PHYS_W), .CNT_W(CNT_W)) u_dut (.*);

  typedef struct { int seq; int arch; int pn; int pp; } ent_t;
  ent_t q[$];
  int mode = 0;  // 0 idle, 1 rolling back, 2 retiring
  int lim = 0;
  int ccnt = 0, ucnt = 0;
  int checks = 0, fails = 0;
  int nseq = 1;

  function automatic bit m_undo();
    return mode == 1 && q.size() > 0 && q[$].seq > lim;
  endfunction
  function automatic bit m_ret();
    return mode == 2 && q.size() > 0 && q[0].seq <= lim;
  endfunction

  // Behavioural reference, stepped on each rising edge.
  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); mode = 0; lim = 0; ccnt = 0; ucnt = 0;
    end else begin
      bit u, r, take;
      u = m_undo(); r = m_ret();
      take = mode == 0 && commit_valid && !squash_valid && q.size() > 0 && q[0].seq <= int'(commit_seq);
      if (push_valid && mode == 0 && !squash_valid && q.size() < DEPTH)
        q.push_back('{int'(push_seq), int'(push_arch), int'(push_new), int'(push_prev)});
      if (u) begin void'(q.pop_back()); ucnt++; end
      if (r) begin void'(q.pop_front()); ccnt++; end
      if (squash_valid) begin mode = 1; lim = int'(squash_seq); end
      else if (take) begin mode = 2; lim = int'(commit_seq); end
      else if ((mode == 1 && !u) || (mode == 2 && !r)) mode = 0;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit u, r;
    int fp;
    u = m_undo(); r = m_ret();
    chk(busy == (mode != 0), "R9 busy", int'(busy), int'(mode != 0));
    chk(int'(count) == q.size(), "R2 count", int'(count), q.size());
    chk(full == (q.size() == DEPTH), "R3 full", int'(full), int'(q.size() == DEPTH));
    chk(restore_valid == u, "R4 restore_valid", int'(restore_valid), int'(u));
    chk(free_valid == (u || r), "R5 free_valid", int'(free_valid), int'(u || r));
    if (u) begin
      chk(int'(restore_arch) == q[$].arch, "R4 restore_arch", int'(restore_arch), q[$].arch);
      chk(int'(restore_phys) == q[$].pp, "R4 restore_phys", int'(restore_phys), q[$].pp);
    end
    if (u || r) begin
      fp = u ? q[$].pn : q[0].pp;
      chk(int'(free_phys) == fp, u ? "R4 free_phys" : "R5 free_phys", int'(free_phys), fp);
    end
    chk(int'(commit_cnt) == ccnt, "R11 commit_cnt", int'(commit_cnt), ccnt);
    chk(int'(undo_cnt) == ucnt, "R11 undo_cnt", int'(undo_cnt), ucnt);
  endtask

  task automatic tick();
    @(negedge clk);
    compare_all();
  endtask

  task automatic do_push(int s);
    push_valid = 1; push_seq = SEQ_W'(s); push_arch = ARCH_W'($urandom);
    push_new = PHYS_W'($urandom); push_prev = PHYS_W'($urandom);
    tick(); push_valid = 0;
  endtask

  task automatic do_commit(int c);
    commit_valid = 1; commit_seq = SEQ_W'(c); tick(); commit_valid = 0;
  endtask

  task automatic do_squash(int s);
    squash_valid = 1; squash_seq = SEQ_W'(s); tick(); squash_valid = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4 * DEPTH && busy; i++) tick();
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && count == 0 && !restore_valid && !free_valid, "R1 reset outputs", int'(count), 0);
    chk(commit_cnt == 0 && undo_cnt == 0, "R1 reset counters", int'(commit_cnt), 0);
    rst_n = 1;
    tick();
    // R2: six records, two sharing seq 12
    do_push(10); do_push(11); do_push(12); do_push(12); do_push(13); do_push(14);
    chk(count == 6, "R2 six pushes", int'(count), 6);
    // R6: stale commit
    do_commit(5);
    chk(!busy && count == 6, "R6 stale commit ignored", int'(busy), 0);
    // R5: commit retires oldest two
    do_commit(11); wait_idle();
    chk(count == 4 && commit_cnt == 2, "R5 retired two", int'(count), 4);
    // R3: push while busy ignored
    commit_valid = 1; commit_seq = 12; tick(); commit_valid = 0;
    do_push(20); wait_idle();
    chk(count == 2, "R3 push during walk ignored", int'(count), 2);
    // R7: commit with squash in same cycle
    squash_valid = 1; squash_seq = 13; commit_valid = 1; commit_seq = 14;
    tick(); squash_valid = 0; commit_valid = 0; wait_idle();
    chk(count == 1 && commit_cnt == 4, "R7 commit beside squash ignored", int'(commit_cnt), 4);
    // R8: squash on empty buffer
    do_commit(13); wait_idle();
    do_squash(0);
    chk(busy && !free_valid, "R8 empty squash busy once", int'(busy), 1);
    tick();
    chk(!busy, "R8 empty squash ends", int'(busy), 0);
    // R10: squash preempts a commit walk
    do_push(30); do_push(31); do_push(32); do_push(33);
    do_commit(32);
    do_squash(31); wait_idle();
    chk(count == 1 && undo_cnt == 3, "R10 rollback took over", int'(count), 1);
    do_squash(0); wait_idle();
    // R3: fill past capacity
    for (int i = 0; i < DEPTH + 2; i++) do_push(40 + i);
    chk(full && count == DEPTH, "R3 full drops extra", int'(count), DEPTH);
    do_squash(0); wait_idle();
    nseq = 100;
    // Mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      int k;
      k = $urandom_range(0, 9);
      if (k < 6) begin
        if (!busy) begin do_push(nseq); if ($urandom_range(0, 2) != 0) nseq++; end
        else tick();
      end else if (k < 8) begin
        do_commit(nseq - $urandom_range(0, 12));
      end else if (k == 8) begin
        do_squash(nseq - $urandom_range(0, 10));
      end else tick();
    end
    wait_idle();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule